// File: doc/BRIEF.md
# Periodic Interval Timer

A register-mapped tick source for a processor subsystem. The system clock first passes through a fixed divide-by-16 prescaler. A 20-bit period counter then steps once per prescaled tick and returns to zero after the programmed limit. Each return to zero is one elapsed period. It raises a status flag and adds one to a 12-bit elapsed-period tally, which saturates. An interrupt line follows the status flag while interrupts are enabled.

Software uses four word registers on a simple strobe bus. The mode word holds the limit, the run enable and the interrupt enable. The status word holds the flag. The other two words give the same packed view: the tally in the upper 12 bits and the live counter in the lower 20. One of them acknowledges on read: it clears the flag and the tally, so a driver can add `tally * (limit+1)` to its time base. The other is a side-effect-free snapshot that can be read at any time. Clearing the run enable does not cut the current period short. The counter finishes it and then parks at zero.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register field, the period counter, the tally and the status flag are zero, `irq_o` is low and `rsp_valid` is low.
- R2: While the timer runs, the period counter advances once every 16 clocks. While the timer is disabled and parked at zero, the prescaler is held at zero. As a result, the first increment after a mode write that sets enable lands exactly 16 clocks after the clock edge that accepts that write.
- R3: A period lasts limit+1 prescaled ticks. When a tick arrives with the counter at or above the limit, the counter returns to zero.
- R4: Each return to zero sets the status flag, which reads in bit 0 of offset 0x4, and adds one to the tally.
- R5: A read of offset 0x8 returns {tally[11:0], counter[19:0]} (tally in bits 31:20) as they stood in the request cycle. It clears the status flag and the tally. If a return to zero falls in that same cycle, the tally becomes 1 and the flag stays set.
- R6: A read of offset 0xC returns the same packed word as offset 0x8 and changes nothing.
- R7: Offset 0x0 is the mode word: limit in bits 19:0, run enable in bit 24, interrupt enable in bit 25. It reads back with all other bits zero.
- R8: The tally saturates at 4095 and does not wrap.
- R9: After the run enable is cleared, the counter keeps stepping until its next return to zero, which is counted as usual. It then stays at zero.
- R10: `irq_o` is high exactly while the status flag is set and the interrupt enable is 1. The interrupt enable has no effect on counting.
- R11: Writes to offsets 0x4, 0x8 and 0xC are ignored.
- R12: A read request produces `rsp_valid` for exactly one cycle, in the cycle after the request, with the data on `rsp_rdata`. Writes produce no response. Only address bits 3:2 select the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Period interrupt |

## Verification
Two things can land in the same clock: an acknowledging read of the value word, and the counter's return to zero. The test provokes this on purpose with a limit of zero, which makes every tick a return to zero, and places the read exactly on a tick edge. The expected result is a tally of one and a status flag that stays set. A cycle-exact reference model in the test also meets this collision, and its mirror case (a mode write that disables the timer in the middle of a period), many times under seeded random traffic. The model judges every read response and the interrupt line on every cycle.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
  // Register select taken from byte address bits 3:2
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VALUE  = 2'd2,
    SEL_IMAGE  = 2'd3
  } reg_sel_e;

  // Mode word flag offsets above the limit field
  localparam int RUN_OFS = 4;
  localparam int IEN_OFS = 5;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PRESC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic tick_o
);
  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold_i) div_q <= '0;
    else                  div_q <= div_q + PRESC_W'(1);
  end

  assign tick_o = &div_q;

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pit_period_counter.sv
module pit_period_counter #(
  parameter int LIMIT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               enable_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [LIMIT_W-1:0] count_o,
  output logic               wrap_o,
  output logic               idle_o
);
  logic [LIMIT_W-1:0] count_q;
  logic               running;

  assign running = enable_i || (count_q != '0);
  assign wrap_o  = tick_i && running && (count_q >= limit_i);
  assign idle_o  = !running;
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  count_q <= '0;
    else if (wrap_o)             count_q <= '0;
    else if (tick_i && running)  count_q <= count_q + LIMIT_W'(1);
  end

  // R2
  step_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_q));
  // R3
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> count_q == '0);
endmodule

// File: rtl/pit_overflow_tracker.sv
module pit_overflow_tracker #(
  parameter int OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic             clear_i,
  output logic [OVF_W-1:0] tally_o,
  output logic             flag_o
);
  localparam logic [OVF_W-1:0] TALLY_MAX = '1;

  logic [OVF_W-1:0] tally_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tally_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (clear_i)
        tally_q <= wrap_i ? OVF_W'(1) : '0;
      else if (wrap_i && tally_q != TALLY_MAX)
        tally_q <= tally_q + OVF_W'(1);
      flag_q <= wrap_i || (flag_q && !clear_i);
    end
  end

  assign tally_o = tally_q;
  assign flag_o  = flag_q;

  // R8
  tally_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tally_q == TALLY_MAX && !clear_i) |=> tally_q == TALLY_MAX);
  // R4
  wrap_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q && tally_q != '0);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int PRESC_W = 4,
  parameter int LIMIT_W = 20,
  parameter int OVF_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [3:0]               bus_addr,
  input  logic [LIMIT_W+OVF_W-1:0] bus_wdata,
  output logic                     rsp_valid,
  output logic [LIMIT_W+OVF_W-1:0] rsp_rdata,
  output logic                     irq_o
);
  localparam int DATA_W  = LIMIT_W + OVF_W;
  localparam int RUN_POS = LIMIT_W + RUN_OFS;
  localparam int IEN_POS = LIMIT_W + IEN_OFS;

  reg_sel_e           sel;
  logic               mode_wr, rd_req, ack_rd;
  logic [LIMIT_W-1:0] limit_q;
  logic               run_q, ien_q;
  logic               tick, idle, wrap, flag;
  logic [LIMIT_W-1:0] count;
  logic [OVF_W-1:0]   tally;
  logic [DATA_W-1:0]  rd_word;
  logic               unused_addr_lsb;

  assign sel             = reg_sel_e'(bus_addr[3:2]);
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign mode_wr         = bus_valid && bus_write && (sel == SEL_MODE);
  assign rd_req          = bus_valid && !bus_write;
  assign ack_rd          = rd_req && (sel == SEL_VALUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
    end else if (mode_wr) begin
      limit_q <= bus_wdata[LIMIT_W-1:0];
      run_q   <= bus_wdata[RUN_POS];
      ien_q   <= bus_wdata[IEN_POS];
    end
  end

  pit_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .hold_i(idle), .tick_o(tick));

  pit_period_counter #(.LIMIT_W(LIMIT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .enable_i(run_q),
    .limit_i(limit_q), .count_o(count), .wrap_o(wrap), .idle_o(idle));

  pit_overflow_tracker #(.OVF_W(OVF_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .clear_i(ack_rd),
    .tally_o(tally), .flag_o(flag));

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_MODE: begin
        rd_word[LIMIT_W-1:0] = limit_q;
        rd_word[RUN_POS]     = run_q;
        rd_word[IEN_POS]     = ien_q;
      end
      SEL_STATUS: rd_word[0] = flag;
      default:    rd_word    = {tally, count};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_word;
    end
  end

  assign irq_o = flag && ien_q;

  // R9
  parked_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && count == '0 && !mode_wr) |=> count == '0);
  // R12
  response_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_req));
  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !mode_wr && !ack_rd) |=> irq_o);
endmodule

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_o;

  always #2.5 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o));

  int          checks = 0;
  int          fails  = 0;
  int unsigned ecnt   = 0;
  int unsigned base   = 0;
  bit          done   = 0;

  // reference state
  int unsigned m_presc, m_cnt, m_ovf, m_lim;
  bit          m_sts, m_en, m_ie, e_rv;
  logic [31:0] e_rd;
  string       e_tag;

  function automatic logic [31:0] packed_view(int unsigned ovf, int unsigned cnt);
    return {ovf[11:0], cnt[19:0]};
  endfunction

  function automatic logic [31:0] mode_view(bit ie, bit en, int unsigned lim);
    return {6'd0, ie, en, 4'd0, lim[19:0]};
  endfunction

  always @(posedge clk) begin
    bit run, tick, wrap, rd, clr, hold;
    int unsigned sel;
    ecnt++;
    if (!rst_n) begin
      m_presc = 0; m_cnt = 0; m_ovf = 0; m_lim = 0;
      m_sts = 0; m_en = 0; m_ie = 0; e_rv = 0; e_rd = '0;
    end else begin
      run  = m_en || m_cnt != 0;
      hold = !run;
      tick = run && m_presc == 15;
      wrap = tick && m_cnt >= m_lim;
      rd   = bus_valid && !bus_write;
      sel  = int'(bus_addr[3:2]);
      clr  = rd && sel == 2;
      e_rv = rd;
      if (rd) begin
        case (sel)
          0: begin e_rd = mode_view(m_ie, m_en, m_lim); e_tag = "R7 mode";   end
          1: begin e_rd = {31'd0, m_sts};               e_tag = "R4 status"; end
          2: begin e_rd = packed_view(m_ovf, m_cnt);    e_tag = "R5 value";  end
          default: begin e_rd = packed_view(m_ovf, m_cnt); e_tag = "R6 image"; end
        endcase
      end
      m_presc = hold ? 0 : (m_presc + 1) % 16;
      if (wrap) m_cnt = 0; else if (tick) m_cnt = m_cnt + 1;
      if (clr) m_ovf = wrap ? 1 : 0;
      else if (wrap && m_ovf != 4095) m_ovf = m_ovf + 1;
      m_sts = wrap || (m_sts && !clr);
      if (bus_valid && bus_write && sel == 0) begin
        m_lim = bus_wdata[19:0]; m_en = bus_wdata[24]; m_ie = bus_wdata[25];
      end
    end
  end

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      expect_eq("R10 irq", {31'd0, irq_o}, {31'd0, m_sts && m_ie});
      expect_eq("R12 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
      if (e_rv) expect_eq(e_tag, rsp_rdata, e_rd);
    end
  end

  task automatic cycle(bit v, bit w, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    cycle(0, 0, 4'h0, 32'h0);
  endtask

  task automatic read_reg(logic [3:0] a, output logic [31:0] d);
    cycle(1, 0, a, 32'h0);
    idle();
    d = rsp_rdata;
  endtask

  task automatic write_reg(logic [3:0] a, logic [31:0] d);
    cycle(1, 1, a, d);
    base = ecnt + 1;
  endtask

  task automatic at_edge(int unsigned k);
    while (ecnt + 2 < base + k) idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    expect_eq("R1 irq", {31'd0, irq_o}, 32'd0);
    expect_eq("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    read_reg(4'hC, d); expect_eq("R1 image", d, 32'd0);
    read_reg(4'h0, d); expect_eq("R1 mode", d, 32'd0);
    // R11: writes to read-only offsets ignored
    cycle(1, 1, 4'h4, 32'hFFFF_FFFF);
    cycle(1, 1, 4'h8, 32'hFFFF_FFFF);
    cycle(1, 1, 4'hC, 32'hFFFF_FFFF);
    read_reg(4'h4, d); expect_eq("R11 status", d, 32'd0);
    read_reg(4'hC, d); expect_eq("R11 image", d, 32'd0);
    read_reg(4'h0, d); expect_eq("R11 mode", d, 32'd0);

    // R2 / R3: limit 2, first period exact
    write_reg(4'h0, 32'h0100_0002);
    at_edge(16); read_reg(4'hC, d); expect_eq("R2 before first tick", d, 32'd0);
    at_edge(18); read_reg(4'hC, d); expect_eq("R2 first tick", d, 32'd1);
    at_edge(48); read_reg(4'h4, d); expect_eq("R3 flag before wrap", d, 32'd0);
    at_edge(50); read_reg(4'h4, d); expect_eq("R3 flag after wrap", d, 32'd1);
    at_edge(52); read_reg(4'hC, d); expect_eq("R3 wrapped view", d, 32'h0010_0000);
    // R9: disable mid-period, period drains
    at_edge(70); cycle(1, 1, 4'h0, 32'h0000_0002);
    at_edge(90); read_reg(4'hC, d); expect_eq("R9 still running", d, 32'h0010_0002);
    at_edge(200); read_reg(4'hC, d); expect_eq("R9 drained", d, 32'h0020_0000);
    at_edge(230); read_reg(4'hC, d); expect_eq("R9 parked", d, 32'h0020_0000);

    // R5: acknowledge read on the same edge as a wrap
    write_reg(4'h0, 32'h0300_0000);
    at_edge(10); read_reg(4'h8, d); expect_eq("R5 ack", d, 32'h0020_0000);
    at_edge(32); read_reg(4'h8, d); expect_eq("R5 ack on wrap", d, 32'h0010_0000);
    at_edge(34); read_reg(4'hC, d); expect_eq("R5 wrap kept", d, 32'h0010_0000);
    expect_eq("R10 irq set", {31'd0, irq_o}, 32'd1);
    at_edge(36); read_reg(4'h4, d); expect_eq("R5 flag kept", d, 32'd1);
    read_reg(4'h0, d); expect_eq("R7 readback", d, 32'h0300_0000);

    // R8: tally saturates
    repeat (16 * 4100) idle();
    read_reg(4'hC, d); expect_eq("R8 saturated", d, 32'hFFF0_0000);

    // Random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r == 0)
        cycle(1, 1, 4'h0, ($urandom & 32'hFCF0_0000) | ($urandom % 6) |
                          (($urandom % 4 != 0) ? 32'h0100_0000 : 0) |
                          (($urandom % 2) ? 32'h0200_0000 : 0));
      else if (r <= 4)
        cycle(1, 0, 4'($urandom % 16), 32'h0);
      else if (r == 5)
        cycle(1, 1, 4'(4 + $urandom % 12), $urandom);
      else
        idle();
    end
    repeat (3) idle();
    finish_run();
  end
endmodule